// File: doc/BRIEF.md
# Oversampled Bitstream Decimator (Third-/First-Order Sinc)

This block turns the one-bit output of a sigma-delta modulator into signed multi-bit conversion results. Each modulator sample counts as +1 for a one and −1 for a zero. A cascade of three integrators runs at the modulator rate. Three differencing stages run once every R samples. Together they form a third-order sinc response, which is the default. Setting the fast control switches to a first-order sinc, which is a plain sum of the last R samples. Both responses share the same decimation ratio, so the notch frequencies do not change, and both are scaled to the same full scale.

The decimation ratio is chosen at run time from a small set of powers of two. A sample only counts on cycles where the modulator clock enable is high. While the sync control is high, the whole filter is held cleared and no results come out. Dropping sync starts conversions from a known point, so settling is predictable. Any change of filter order or ratio restarts the filter in the same way. After a restart, results are withheld until the filter has settled: one output period for the first-order response and three for the third-order response.

Top module: `sinc_decim`

## Requirements
- R1: A sample of 1 counts as +1 and a 0 as −1. With default parameters, the full scale of `result` is ±2^18 for every ratio and both orders: an all-ones stream gives +262144 and an all-zeros stream gives −262144.
- R2: With `fast`=0, each result equals the sum of the most recent 3R−2 samples weighted by the convolution of three length-R boxcars (third-order sinc), multiplied by 2^(3·(6−log2 R)).
- R3: With `fast`=1, each result equals the sum of the most recent R samples multiplied by 2^(18−log2 R). This gives the same full scale as R2.
- R4: The decimation ratio is R = 2^(3+`rate_sel`), which is 8, 16, 32 or 64. A result point falls on every R-th cycle with `mod_en`=1. Cycles with `mod_en`=0 are ignored, whatever the value of `mod_bit`.
- R5: After a restart, the first two result points of the third-order response produce no strobe, and strobes start at the third. The first-order response strobes from the first result point on.
- R6: While `sync`=1, the filter state is cleared and `result_valid` stays low. After `sync` returns to 0, samples are counted from zero.
- R7: A change of `fast` or `rate_sel` with `sync`=0 restarts the filter as in R6. The sample presented in the cycle of the change is discarded, even if it would have completed a period.
- R8: `result_valid` is a single-cycle pulse, high in the cycle after the clock edge that takes the R-th sample. `result` changes only together with that pulse and holds its value otherwise.
- R9: After reset, `result` is 0 and `result_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | High on cycles that carry a modulator sample |
| mod_bit | input | 1 | Modulator bitstream sample |
| rate_sel | input | SEL_W (2) | Decimation ratio select, R = 2^(BASE_LOG2+rate_sel) |
| fast | input | 1 | 0 selects the third-order sinc, 1 the first-order sinc |
| sync | input | 1 | Holds the filter cleared while high |
| result | output | OUT_W (20) | Two's-complement conversion result |
| result_valid | output | 1 | One-cycle strobe marking a new settled result |

## Verification
A configuration change and a completing sample can land in the same cycle. The restart must win: the sample is dropped and no strobe follows. The bench provokes this by stopping a third-order stream one sample short of a period boundary. It then switches to first-order mode while presenting a sample in the very cycle that would have completed the period. It then checks that no strobe appears after that edge. It also checks that the following results match a model whose sample history begins after the dropped sample. A ratio change without sync is exercised the same way.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

    typedef enum logic {
        FILT_SINC3 = 1'b0,
        FILT_SINC1 = 1'b1
    } filt_e;

    localparam int NSTAGE = 3;

    // width that holds +/- full scale 2^(3*max_log2) in two's complement
    function automatic int acc_width(input int max_log2);
        return NSTAGE * max_log2 + 2;
    endfunction

endpackage

// File: rtl/sinc_ctrl.sv
module sinc_ctrl
    import sinc_pkg::*;
#(
    parameter int BASE_LOG2 = 3,
    parameter int SEL_W     = 2,
    parameter int MAX_LOG2  = 6,
    parameter int LR_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             fast,
    input  logic             sync,
    output logic             clear,
    output logic             dec_stb,
    output logic             settled,
    output logic [LR_W-1:0]  log2r
);

    typedef struct packed {
        logic [MAX_LOG2-1:0] cnt;
        logic [1:0]          settle;
        logic                fast;
        logic [SEL_W-1:0]    rate;
    } ctrl_t;

    ctrl_t               st_q, st_d;
    logic [MAX_LOG2-1:0] lim;
    logic [1:0]          need_m1;

    always_comb begin
        log2r   = LR_W'(BASE_LOG2) + LR_W'(st_q.rate);
        lim     = {MAX_LOG2{1'b1}} >> (LR_W'(MAX_LOG2) - log2r);
        clear   = sync || (fast != st_q.fast) || (rate_sel != st_q.rate);
        dec_stb = mod_en && !clear && (st_q.cnt == lim);
        need_m1 = (filt_e'(fast) == FILT_SINC1) ? 2'd0 : 2'd2;
        settled = (st_q.settle >= need_m1);

        st_d      = st_q;
        st_d.fast = fast;
        st_d.rate = rate_sel;
        if (clear) begin
            st_d.cnt    = '0;
            st_d.settle = '0;
        end else if (mod_en) begin
            st_d.cnt = dec_stb ? '0 : st_q.cnt + MAX_LOG2'(1);
            if (dec_stb && st_q.settle != 2'd3)
                st_d.settle = st_q.settle + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fast) != fast) |=> (st_q.cnt == '0 && st_q.settle == '0));

endmodule

// File: rtl/sinc_integ.sv
module sinc_integ
    import sinc_pkg::*;
#(
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             mod_en,
    input  logic             mod_bit,
    output logic [ACC_W-1:0] i1_nxt,
    output logic [ACC_W-1:0] i3_nxt
);

    typedef struct packed {
        logic [NSTAGE-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t                       st_q, st_d;
    logic [NSTAGE-1:0][ACC_W-1:0] sum;
    logic [ACC_W-1:0]             x;

    always_comb begin
        x      = mod_bit ? ACC_W'(1) : '1;
        sum[0] = st_q.acc[0] + x;
        for (int s = 1; s < NSTAGE; s++)
            sum[s] = st_q.acc[s] + sum[s-1];
        i1_nxt = sum[0];
        i3_nxt = sum[NSTAGE-1];

        st_d = st_q;
        if (clear)       st_d.acc = '0;
        else if (mod_en) st_d.acc = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.acc[0] == '0));

endmodule

// File: rtl/sinc_comb.sv
module sinc_comb
    import sinc_pkg::*;
#(
    parameter int ACC_W    = 20,
    parameter int MAX_LOG2 = 6,
    parameter int LR_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             dec_stb,
    input  logic             settled,
    input  logic             fast,
    input  logic [LR_W-1:0]  log2r,
    input  logic [ACC_W-1:0] i1_nxt,
    input  logic [ACC_W-1:0] i3_nxt,
    output logic [ACC_W-1:0] result,
    output logic             result_valid
);

    typedef struct packed {
        logic [ACC_W-1:0]             tap1;
        logic [NSTAGE-1:0][ACC_W-1:0] dly;
        logic [ACC_W-1:0]             res;
        logic                         vld;
    } comb_t;

    comb_t                        st_q, st_d;
    logic [NSTAGE-1:0][ACC_W-1:0] diff;
    logic [ACC_W-1:0]             box;
    int                           sh3, sh1;

    always_comb begin
        diff[0] = i3_nxt - st_q.dly[0];
        for (int s = 1; s < NSTAGE; s++)
            diff[s] = diff[s-1] - st_q.dly[s];
        box = i1_nxt - st_q.tap1;
        sh3 = NSTAGE * (MAX_LOG2 - int'(log2r));
        sh1 = NSTAGE * MAX_LOG2 - int'(log2r);

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clear) begin
            st_d.tap1 = '0;
            st_d.dly  = '0;
        end else if (dec_stb) begin
            st_d.tap1   = i1_nxt;
            st_d.dly[0] = i3_nxt;
            for (int s = 1; s < NSTAGE; s++)
                st_d.dly[s] = diff[s-1];
            if (settled) begin
                st_d.vld = 1'b1;
                st_d.res = (filt_e'(fast) == FILT_SINC1) ? (box << sh1)
                                                         : (diff[NSTAGE-1] << sh3);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result       = st_q.res;
    assign result_valid = st_q.vld;

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld |-> $stable(st_q.res));

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
    import sinc_pkg::*;
#(
    parameter int  BASE_LOG2 = 3,
    parameter int  SEL_W     = 2,
    localparam int MAX_LOG2  = BASE_LOG2 + (1 << SEL_W) - 1,
    localparam int OUT_W     = sinc_pkg::acc_width(MAX_LOG2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic             mod_bit,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             fast,
    input  logic             sync,
    output logic [OUT_W-1:0] result,
    output logic             result_valid
);

    localparam int     LR_W = $clog2(MAX_LOG2 + 1);
    localparam longint FS   = longint'(1) << (NSTAGE * MAX_LOG2);

    logic             clear, dec_stb, settled;
    logic [LR_W-1:0]  log2r;
    logic [OUT_W-1:0] i1_nxt, i3_nxt;

    sinc_ctrl #(
        .BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2), .LR_W(LR_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .rate_sel(rate_sel),
        .fast(fast), .sync(sync), .clear(clear), .dec_stb(dec_stb),
        .settled(settled), .log2r(log2r)
    );

    sinc_integ #(.ACC_W(OUT_W)) u_integ (
        .clk(clk), .rst_n(rst_n), .clear(clear), .mod_en(mod_en),
        .mod_bit(mod_bit), .i1_nxt(i1_nxt), .i3_nxt(i3_nxt)
    );

    sinc_comb #(.ACC_W(OUT_W), .MAX_LOG2(MAX_LOG2), .LR_W(LR_W)) u_comb (
        .clk(clk), .rst_n(rst_n), .clear(clear), .dec_stb(dec_stb),
        .settled(settled), .fast(fast), .log2r(log2r), .i1_nxt(i1_nxt),
        .i3_nxt(i3_nxt), .result(result), .result_valid(result_valid)
    );

    // R6
    sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !result_valid);

    // R4
    valid_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(mod_en));

    // R1
    full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (longint'($signed(result)) <= FS &&
                          longint'($signed(result)) >= -FS));

endmodule

// File: tb/sinc_decim_bench.sv
module sinc_decim_bench;

    localparam int CLK_P = 10;
    localparam int BASE  = 3;
    localparam int K     = 6;
    localparam int OUT_W = 3 * K + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mod_en = 1'b0, mod_bit = 1'b0, fast = 1'b0, sync = 1'b1;
    logic [1:0] rate_sel = 2'd0;
    logic signed [OUT_W-1:0] result;
    logic result_valid;

    always #(CLK_P/2) clk = ~clk;

    sinc_decim u_sinc_decim (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
        .rate_sel(rate_sel), .fast(fast), .sync(sync),
        .result(result), .result_valid(result_valid)
    );

    typedef struct packed {
        logic       f;
        logic [1:0] rt;
        logic [4:0] d0;
        logic [4:0] d1;
        logic [9:0] step;
        logic       gap;
        logic [3:0] nper;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 5'd16, 5'd16, 10'd0,   1'b0, 4'd6},
        '{1'b0, 2'd0, 5'd0,  5'd0,  10'd0,   1'b0, 4'd6},
        '{1'b0, 2'd1, 5'd8,  5'd8,  10'd0,   1'b0, 4'd5},
        '{1'b0, 2'd2, 5'd5,  5'd12, 10'd64,  1'b0, 4'd6},
        '{1'b1, 2'd0, 5'd12, 5'd12, 10'd0,   1'b0, 4'd4},
        '{1'b1, 2'd3, 5'd3,  5'd14, 10'd100, 1'b0, 4'd4},
        '{1'b0, 2'd1, 5'd11, 5'd11, 10'd0,   1'b1, 4'd5},
        '{1'b1, 2'd1, 5'd16, 5'd16, 10'd0,   1'b1, 4'd3},
        '{1'b0, 2'd3, 5'd9,  5'd9,  10'd0,   1'b0, 4'd4}
    };

    int n_chk = 0, n_bad = 0;
    int hist [0:1023];
    int nsamp, pdm_acc;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // moving-sum model over the sample history since the last restart
    function automatic longint expv(input bit f, input int k, input int n);
        int r = 1 << k;
        longint s = 0;
        if (f) begin
            for (int j = 0; j < r; j++)
                if (n - j >= 1) s += hist[n-j];
            return s <<< (3 * K - k);
        end
        for (int j = 0; j <= 3 * r - 3; j++) begin
            longint w = 0;
            for (int a = 0; a < r; a++) begin
                int m = j - a;
                if (m >= 0 && m <= 2 * r - 2) w += (m < r) ? (m + 1) : (2 * r - 1 - m);
            end
            if (n - j >= 1) s += w * hist[n-j];
        end
        return s <<< (3 * (K - k));
    endfunction

    task automatic run_stream(input vec_t v, input bit use_sync, input int trim);
        int k = BASE + int'(v.rt);
        int r = 1 << k;
        int need = v.f ? 1 : 3;
        int total = int'(v.nper) * r - trim;
        bit last_en = 1'b0;
        bit tog = 1'b0;
        string tag;
        if (v.gap) tag = "R4";
        else if (v.d0 == v.d1 && (v.d0 == 5'd16 || v.d0 == 5'd0)) tag = "R1";
        else tag = v.f ? "R3" : "R2";

        fast = v.f; rate_sel = v.rt; mod_en = 1'b1; mod_bit = 1'b1;
        if (use_sync) sync = 1'b1;
        @(posedge clk); @(negedge clk);
        // R6 / R7: the restart cycle never yields a strobe, even on a period boundary
        chk(!result_valid, use_sync ? "R6" : "R7", longint'(result_valid), 0);
        sync = 1'b0;
        nsamp = 0; pdm_acc = 0;
        forever begin
            if (last_en && (nsamp % r) == 0) begin
                bit ev = (nsamp / r) >= need;
                // R5 settling gate
                chk(result_valid == ev, "R5", longint'(result_valid), longint'(ev));
                if (ev && result_valid)
                    chk(longint'(result) == expv(v.f, k, nsamp), tag,
                        longint'(result), expv(v.f, k, nsamp));
            end else if (result_valid) begin
                // R8 strobe only after a period-completing sample
                chk(1'b0, "R8", 1, 0);
            end
            if (nsamp == total) break;
            tog = ~tog;
            mod_en = v.gap ? tog : 1'b1;
            if (mod_en) begin
                int dens = (nsamp < int'(v.step)) ? int'(v.d0) : int'(v.d1);
                bit b;
                pdm_acc += dens;
                b = (pdm_acc >= 16);
                if (b) pdm_acc -= 16;
                nsamp++;
                hist[nsamp] = b ? 1 : -1;
                mod_bit = b;
            end else begin
                mod_bit = ~mod_bit;
            end
            last_en = mod_en;
            @(posedge clk); @(negedge clk);
        end
        mod_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t cv;
        int seen = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(result == '0, "R9", longint'(result), 0);
        chk(!result_valid, "R9", longint'(result_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: sync held with live samples never strobes
        sync = 1'b1; mod_en = 1'b1;
        for (int i = 0; i < 200; i++) begin
            mod_bit = i[0];
            @(posedge clk); @(negedge clk);
            if (result_valid) seen++;
        end
        chk(seen == 0, "R6", longint'(seen), 0);

        for (int i = 0; i < NV; i++)
            run_stream(VECS[i], 1'b1, 0);

        // R7: change of order lands on a period-completing sample
        cv = '{1'b0, 2'd0, 5'd13, 5'd13, 10'd0, 1'b0, 4'd3};
        run_stream(cv, 1'b1, 1);
        cv = '{1'b1, 2'd0, 5'd4, 5'd4, 10'd0, 1'b0, 4'd3};
        run_stream(cv, 1'b0, 0);
        // R7: ratio change without sync
        cv = '{1'b1, 2'd2, 5'd6, 5'd10, 10'd40, 1'b0, 4'd2};
        run_stream(cv, 1'b0, 0);
        // R7: back to third order without sync
        cv = '{1'b0, 2'd2, 5'd10, 5'd10, 10'd0, 1'b0, 4'd4};
        run_stream(cv, 1'b0, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule